// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block drives an active-high reset to a processor. An analog comparator, outside the block, reports whether the supply is above the current trip threshold. That flag enters through a two-flop synchronizer. Reset is forced high whenever the synchronized flag says the supply is low. Reset is released only after the flag has stayed high for `TIMEOUT` clock cycles without a break. A power-on input restarts the same wait, so the processor is held in reset while the supply and the oscillator settle.

The block also holds a small trip-code register that selects the comparator threshold. It is reprogrammed by a pin-level sequence. Digital strobes stand in for the high-voltage levels that would sit on the serial clock and data pins. A new code is accepted directly when it raises the threshold. Lowering the threshold, or keeping it equal, is possible only after a separate strobe has put the code back to its default.

Top module: `supply_reset_seq`

## Requirements
- R1: While `power_on` is high, `rst_out` is 1 and `trip_code` equals `DEF_CODE` (2 by default). Once `power_on` has fallen with `supply_ok` already high, `rst_out` falls at the `TIMEOUT+2`-th rising clock edge after the fall, and not before.
- R2: A low level on `supply_ok` that is set up before a rising edge drives `rst_out` to 1 after the second rising edge, and `rst_out` stays 1 as long as `supply_ok` stays low.
- R3: After `supply_ok` returns high, `rst_out` falls at the `TIMEOUT+2`-th rising edge. The first two edges are synchronizer latency.
- R4: A dip of even one cycle on `supply_ok` during the wait restarts the wait from zero. Release then again comes `TIMEOUT+2` edges after the return, whatever count had been reached before the dip.
- R5: Programming is entered only while `prg_cs`, `prg_wp`, `prg_clk_hv` and `prg_dat_hv` are all 1. If any one of them is 0, the sequence leaves `trip_code` unchanged.
- R6: Once the sequence has been entered, `prg_cs` going 0 and then back to 1 commits `prg_code`. `trip_code` takes the value at the edge that samples `prg_cs` high again.
- R7: A committed code greater than the current `trip_code` (unsigned compare) is written.
- R8: A committed code less than or equal to the current `trip_code` is refused unless a default restore has happened since the last commit or power-on.
- R9: A one-cycle pulse on `code_dflt` sets `trip_code` to `DEF_CODE` at the next edge. It also allows exactly one following commit of any value. If `code_dflt` and a commit occur in the same cycle, the restore wins.
- R10: Power-on locks lowering. After `power_on`, a lower code is refused until `code_dflt` has been pulsed.
- R11: If `prg_clk_hv`, `prg_dat_hv` or `prg_wp` falls before `prg_cs` returns high, the sequence ends without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| power_on | input | 1 | Active-high power-on indication, asynchronous |
| supply_ok | input | 1 | Raw comparator flag, 1 when supply is above the threshold |
| prg_cs | input | 1 | Chip-select pin level used by the programming sequence |
| prg_wp | input | 1 | Write-protect pin level, must be 1 to program |
| prg_clk_hv | input | 1 | Strobe standing for the programming level on the serial clock pin |
| prg_dat_hv | input | 1 | Strobe standing for the programming level on the serial data pin |
| prg_code | input | CODE_W | Trip code offered for commit |
| code_dflt | input | 1 | Restore-to-default strobe |
| rst_out | output | 1 | Active-high processor reset |
| trip_code | output | CODE_W | Current threshold code |

## Verification
The reset output has a fixed latency. It rises two edges after `supply_ok` falls, and it falls `TIMEOUT+2` edges after `supply_ok` rises or `power_on` falls. The bench drives every input on a falling edge and samples `rst_out` on each falling edge of the release window, so the last edge with reset high and the first with reset low are both checked. A code commit takes effect at the edge that samples `prg_cs` high again, and a default restore at the edge after its pulse. The bench reads `trip_code` one falling edge after that edge. It sweeps all current and offered code pairs, with and without a prior restore.

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int unsigned TIMEOUT  = 20_000_000,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned DEF_CODE = 2
) (
  input  logic              clk,
  input  logic              power_on,
  input  logic              supply_ok,
  input  logic              prg_cs,
  input  logic              prg_wp,
  input  logic              prg_clk_hv,
  input  logic              prg_dat_hv,
  input  logic [CODE_W-1:0] prg_code,
  input  logic              code_dflt,
  output logic              rst_out,
  output logic [CODE_W-1:0] trip_code
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  localparam logic [CODE_W-1:0] DEFV = CODE_W'(DEF_CODE);

  logic          vs1, vs2;
  logic [CW-1:0] cnt;
  logic          done;

  assign done    = (cnt == LIMIT);
  assign rst_out = !vs2 || !done;

  always_ff @(posedge clk or posedge power_on)
    if (power_on) begin
      vs1 <= 1'b0;
      vs2 <= 1'b0;
      cnt <= '0;
    end else begin
      vs1 <= supply_ok;
      vs2 <= vs1;
      if (!vs2)      cnt <= '0;
      else if (!done) cnt <= cnt + 1'b1;
    end

  logic lvl, entered, low_seen, unlocked, commit;

  assign lvl    = prg_wp && prg_clk_hv && prg_dat_hv;
  assign commit = lvl && entered && low_seen && prg_cs;

  always_ff @(posedge clk or posedge power_on)
    if (power_on) begin
      entered  <= 1'b0;
      low_seen <= 1'b0;
    end else if (!lvl) begin
      entered  <= 1'b0;
      low_seen <= 1'b0;
    end else if (!entered) begin
      entered <= prg_cs;
    end else if (!prg_cs) begin
      low_seen <= 1'b1;
    end else if (low_seen) begin
      low_seen <= 1'b0;
    end

  always_ff @(posedge clk or posedge power_on)
    if (power_on) begin
      trip_code <= DEFV;
      unlocked  <= 1'b0;
    end else if (code_dflt) begin
      trip_code <= DEFV;
      unlocked  <= 1'b1;
    end else if (commit) begin
      if (unlocked || prg_code > trip_code) trip_code <= prg_code;
      unlocked <= 1'b0;
    end
endmodule

module supply_reset_chk #(
  parameter int unsigned TIMEOUT  = 20_000_000,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned DEF_CODE = 2
) (
  input logic              clk,
  input logic              power_on,
  input logic              vsync,
  input logic              rst_out,
  input logic [CODE_W-1:0] trip_code,
  input logic              code_dflt,
  input logic              commit,
  input logic              unlocked
);
  int unsigned run;

  always_ff @(posedge clk or posedge power_on)
    if (power_on)       run <= 0;
    else if (!vsync)    run <= 0;
    else if (run < TIMEOUT) run <= run + 1;

  // R3
  release_window_chk: assert property (@(posedge clk) disable iff (power_on)
    rst_out == !(vsync && run >= TIMEOUT));

  // R2
  low_holds_chk: assert property (@(posedge clk) disable iff (power_on)
    !vsync |-> rst_out);

  // R4
  fell_needs_supply_chk: assert property (@(posedge clk) disable iff (power_on)
    $fell(rst_out) |-> vsync && $past(vsync));

  // R6
  code_cause_chk: assert property (@(posedge clk) disable iff (power_on)
    !$stable(trip_code) |-> $past(code_dflt) || $past(commit));

  // R8
  no_lower_chk: assert property (@(posedge clk) disable iff (power_on)
    ($past(commit) && !$past(code_dflt) && !$past(unlocked)) |-> trip_code >= $past(trip_code));

  // R9
  dflt_value_chk: assert property (@(posedge clk) disable iff (power_on)
    $past(code_dflt) |-> trip_code == CODE_W'(DEF_CODE));
endmodule

bind supply_reset_seq supply_reset_chk #(.TIMEOUT(TIMEOUT), .CODE_W(CODE_W), .DEF_CODE(DEF_CODE)) i_chk (
  .clk(clk), .power_on(power_on), .vsync(vs2), .rst_out(rst_out), .trip_code(trip_code),
  .code_dflt(code_dflt), .commit(commit), .unlocked(unlocked));

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;
  localparam int CLK_P = 10;
  localparam int T     = 8;
  localparam int CW    = 3;
  localparam int DEF   = 2;

  logic clk = 0, power_on = 1, supply_ok = 0;
  logic prg_cs = 1, prg_wp = 0, prg_clk_hv = 0, prg_dat_hv = 0, code_dflt = 0;
  logic [CW-1:0] prg_code = '0;
  logic rst_out;
  logic [CW-1:0] trip_code;

  int checks = 0, failures = 0;
  int exp_code;
  bit exp_unlk;

  supply_reset_seq #(.TIMEOUT(T), .CODE_W(CW), .DEF_CODE(DEF)) i_supply_reset_seq (
    .clk(clk), .power_on(power_on), .supply_ok(supply_ok), .prg_cs(prg_cs), .prg_wp(prg_wp),
    .prg_clk_hv(prg_clk_hv), .prg_dat_hv(prg_dat_hv), .prg_code(prg_code),
    .code_dflt(code_dflt), .rst_out(rst_out), .trip_code(trip_code));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic release_window(input string req);
    for (int e = 1; e <= T + 2; e++) begin
      @(negedge clk);
      chk(rst_out == (e < T + 2), req, rst_out, e < T + 2);
    end
  endtask

  task automatic restore();
    @(negedge clk); code_dflt = 1;
    @(negedge clk); code_dflt = 0;
    exp_code = DEF; exp_unlk = 1;
    chk(trip_code == DEF, "R9", trip_code, DEF);
  endtask

  task automatic prog(input int code, input bit wp, input bit ck, input bit dt, input bit abort);
    bit ok;
    @(negedge clk);
    prg_wp = wp; prg_clk_hv = ck; prg_dat_hv = dt; prg_cs = 1; prg_code = CW'(code);
    @(negedge clk); prg_cs = 0;
    @(negedge clk); if (abort) prg_clk_hv = 0; prg_cs = 1;
    @(negedge clk); prg_wp = 0; prg_clk_hv = 0; prg_dat_hv = 0;
    ok = wp && ck && dt && !abort;
    if (ok) begin
      if (exp_unlk || code > exp_code) exp_code = code;
      exp_unlk = 0;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_code = DEF; exp_unlk = 0;
    repeat (3) @(negedge clk);
    chk(rst_out == 1, "R1", rst_out, 1);
    chk(trip_code == DEF, "R1", trip_code, DEF);
    supply_ok = 1; power_on = 0;
    release_window("R1");

    // R2: fall latency and hold
    @(negedge clk); supply_ok = 0;
    @(negedge clk); chk(rst_out == 0, "R2", rst_out, 0);
    @(negedge clk); chk(rst_out == 1, "R2", rst_out, 1);
    repeat (T + 4) @(negedge clk);
    chk(rst_out == 1, "R2", rst_out, 1);
    supply_ok = 1;
    release_window("R3");

    // R4: one-cycle dip at every partial count
    for (int p = 0; p < T; p++) begin
      supply_ok = 0;
      repeat (3) @(negedge clk);
      supply_ok = 1;
      repeat (p + 2) @(negedge clk);
      supply_ok = 0;
      @(negedge clk); supply_ok = 1;
      release_window("R4");
    end

    // R7/R8/R9: all current/offered pairs
    for (int c = 0; c < 8; c++)
      for (int n = 0; n < 8; n++) begin
        restore();
        prog(c, 1, 1, 1, 0);
        chk(trip_code == c, "R9", trip_code, c);
        prog(n, 1, 1, 1, 0);
        chk(trip_code == exp_code, (n > c) ? "R7" : "R8", trip_code, exp_code);
        chk(trip_code == ((n > c) ? n : c), "R6", trip_code, (n > c) ? n : c);
      end

    // R5: each enable missing
    restore();
    prog(1, 1, 1, 1, 0);
    prog(6, 0, 1, 1, 0); chk(trip_code == 1, "R5", trip_code, 1);
    prog(6, 1, 0, 1, 0); chk(trip_code == 1, "R5", trip_code, 1);
    prog(6, 1, 1, 0, 0); chk(trip_code == 1, "R5", trip_code, 1);
    // R11: level removed before CS returns
    prog(6, 1, 1, 1, 1); chk(trip_code == 1, "R11", trip_code, 1);
    prog(6, 1, 1, 1, 0); chk(trip_code == 6, "R7", trip_code, 6);

    // R9: restore wins over same-cycle commit
    @(negedge clk);
    prg_wp = 1; prg_clk_hv = 1; prg_dat_hv = 1; prg_cs = 1; prg_code = 3'd7;
    @(negedge clk); prg_cs = 0;
    @(negedge clk); prg_cs = 1; code_dflt = 1;
    @(negedge clk); code_dflt = 0; prg_wp = 0; prg_clk_hv = 0; prg_dat_hv = 0;
    chk(trip_code == DEF, "R9", trip_code, DEF);
    exp_code = DEF; exp_unlk = 1;

    // R10: power-on relocks
    prog(5, 1, 1, 1, 0);
    @(negedge clk); power_on = 1;
    @(negedge clk); chk(trip_code == DEF, "R10", trip_code, DEF);
    chk(rst_out == 1, "R1", rst_out, 1);
    power_on = 0; exp_code = DEF; exp_unlk = 0;
    prog(0, 1, 1, 1, 0);
    chk(trip_code == DEF, "R10", trip_code, DEF);
    restore();
    prog(0, 1, 1, 1, 0);
    chk(trip_code == 0, "R10", trip_code, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule